// File: doc/BRIEF.md
# Instruction Trace Exception Controller

This block sits beside a processor core and decides, instruction by instruction, whether the core must take a trace exception once the current instruction has finished. A two-bit trace field in the status register selects the policy. Three policies exist: tracing is off, the core traces only instructions that break sequential program flow, or the core traces every instruction that completes. The block captures the field when an instruction starts. It then watches that instruction's events until the instruction retires, is cancelled, or is aborted by a memory fault.

When a trace is due, the block raises a level request. It also presents the four words the core's stack-write sequencer pushes: the address of the traced instruction, the trace vector offset, the address of the next instruction, and the status register as it stood at retirement. The request stays high until the core acknowledges it. While the request is high, the block ignores all instruction events, so the exception sequence is never traced.

When a bus or address fault aborts an instruction, the block saves that instruction's trace context. The fault handler then runs. The return-from-exception that resumes the faulted instruction is marked by a flag, is never traced itself, and puts the saved context back. The resumed instruction then raises its trace when it completes.

Top module: `trace_exc_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `trace_req_o` is low, no trace context is pending or deferred, and a retire with no preceding start raises no trace.
- R2: With trace field `sr_i[15:14]` = 2'b10 at instruction start, a retire raises `trace_req_o` on the next clock edge. The frame then carries the start address, `next_pc_i` at retire and `sr_i` at retire.
- R3: The trace field applies as captured at instruction start. Changes to `sr_i[15:14]` after the start cycle do not affect that instruction.
- R4: With trace field 2'b01, a retire raises a trace only if `pc_jump_i` or `br_taken_i` was high at some cycle from start to retire. A retire without either raises none.
- R5: Trace field 2'b00 and the reserved value 2'b11 raise no trace, even when flow changes.
- R6: `irq_take_i` or `fault_i` cancels the current instruction. No trace is raised, and a later retire without a new start raises none.
- R7: `abort_i` defers the instruction's trace. After a retire carrying `rte_resume_i`, the next retire raises that trace with the faulted instruction's address and captured mode.
- R8: A retire with `rte_resume_i` high never raises a trace, even with trace field 2'b10.
- R9: `trace_req_o` stays high, and all frame outputs stay unchanged, until a cycle with `trace_ack_i` high. The request drops on the edge that follows that cycle.
- R10: Instruction events that arrive while `trace_req_o` is high are ignored and raise no later trace.
- R11: `frm_vec_off_o` is 12'h024, the offset of trace vector 9.
- R12: An instruction whose start and retire fall in the same cycle uses the trace field on `sr_i` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_i | input | 16 | Status register; bits 15:14 hold the trace field |
| insn_start_i | input | 1 | Instruction begins this cycle |
| insn_addr_i | input | 32 | Address of the instruction starting |
| pc_jump_i | input | 1 | PC left sequential order this cycle |
| br_taken_i | input | 1 | Branch taken this cycle |
| retire_i | input | 1 | Instruction completes this cycle |
| next_pc_i | input | 32 | Address of the next instruction, valid with retire |
| irq_take_i | input | 1 | Interrupt accepted instead of the instruction |
| fault_i | input | 1 | Illegal, unimplemented or privileged fault |
| abort_i | input | 1 | Bus or address error aborts the instruction |
| rte_resume_i | input | 1 | Retiring instruction is a return that resumes a faulted instruction |
| trace_ack_i | input | 1 | Core acknowledges the trace request |
| trace_req_o | output | 1 | Trace exception request (level) |
| frm_insn_addr_o | output | 32 | Frame: traced instruction address |
| frm_vec_off_o | output | 12 | Frame: trace vector offset |
| frm_next_pc_o | output | 32 | Frame: next instruction address |
| frm_sr_o | output | 16 | Frame: status register copy |

## Verification
The deferred path is the hardest case to reach from the ports. It needs an instruction aborted under every-instruction tracing, then a handler instruction with tracing off, then a resume-flagged return that runs with tracing on, and finally a lone retire that stands for the restarted instruction. The stimulus plays this exact sequence and expects exactly one frame, holding the aborted instruction's address. A second hard case is holding the acknowledge off for several cycles while a complete traced instruction runs under the open request. This shows that such events leave no trace behind.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    TM_OFF  = 2'b00,
    TM_FLOW = 2'b01,
    TM_EACH = 2'b10,
    TM_RSVD = 2'b11
  } tmode_t;

  localparam int unsigned TRACE_VEC = 9;

  function automatic logic [11:0] vec_offset(input int unsigned vec);
    return 12'(vec * 4);
  endfunction
endpackage

// File: rtl/trace_ctx.sv
module trace_ctx
  import trace_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SRW = 16,
  parameter int THI = 15
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold_i,
  input  logic [SRW-1:0] sr_i,
  input  logic           start_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           flow_i,
  input  logic           retire_i,
  input  logic           irq_i,
  input  logic           fault_i,
  input  logic           abort_i,
  input  logic           rte_i,
  output logic           fire_o,
  output logic [AW-1:0]  addr_o
);
  tmode_t          mode_q, dmode_q, mode_eff;
  logic            act_q, flow_q, dval_q, dflow_q;
  logic [AW-1:0]   addr_q, daddr_q, addr_eff;
  logic            act_eff, flow_eff;
  logic            st, rt, cancel, ab, fl;

  // all events are masked while a trace exception is in progress
  assign st     = start_i  & ~hold_i;
  assign rt     = retire_i & ~hold_i;
  assign cancel = (irq_i | fault_i) & ~hold_i;
  assign ab     = abort_i  & ~hold_i;
  assign fl     = flow_i   & ~hold_i;

  always_comb begin
    mode_eff = st ? tmode_t'(sr_i[THI -: 2]) : mode_q;
    addr_eff = st ? addr_i : addr_q;
    act_eff  = st | act_q;
    flow_eff = (st ? 1'b0 : flow_q) | fl;
  end

  assign fire_o = rt & act_eff & ~rte_i & ~cancel & ~ab &
                  ((mode_eff == TM_EACH) | ((mode_eff == TM_FLOW) & flow_eff));
  assign addr_o = addr_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      flow_q  <= 1'b0;
      mode_q  <= TM_OFF;
      addr_q  <= '0;
      dval_q  <= 1'b0;
      dflow_q <= 1'b0;
      dmode_q <= TM_OFF;
      daddr_q <= '0;
    end else if (rt && rte_i && dval_q) begin
      // resume of a faulted instruction: restore its saved context
      act_q  <= 1'b1;
      mode_q <= dmode_q;
      addr_q <= daddr_q;
      flow_q <= dflow_q;
      dval_q <= 1'b0;
    end else if (rt || cancel) begin
      act_q  <= 1'b0;
      flow_q <= 1'b0;
    end else if (ab) begin
      dval_q  <= act_eff;
      dmode_q <= mode_eff;
      daddr_q <= addr_eff;
      dflow_q <= flow_eff;
      act_q   <= 1'b0;
      flow_q  <= 1'b0;
    end else if (act_eff) begin
      act_q  <= 1'b1;
      mode_q <= mode_eff;
      addr_q <= addr_eff;
      flow_q <= flow_eff;
    end
  end

  a_r8_rte_silent: assert property (@(posedge clk) disable iff (rst)
    (retire_i && rte_i) |-> !fire_o);
  a_r10_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    hold_i |-> !fire_o);
  a_r6_cancel_clears: assert property (@(posedge clk) disable iff (rst)
    ((irq_i || fault_i) && !hold_i) |=> !act_q);
endmodule

// File: rtl/trace_frame.sv
module trace_frame #(
  parameter int AW  = 32,
  parameter int SRW = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           fire_i,
  input  logic           ack_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [AW-1:0]  npc_i,
  input  logic [SRW-1:0] sr_i,
  output logic           req_o,
  output logic [AW-1:0]  addr_o,
  output logic [AW-1:0]  npc_o,
  output logic [SRW-1:0] sr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_o  <= 1'b0;
      addr_o <= '0;
      npc_o  <= '0;
      sr_o   <= '0;
    end else if (fire_i && !req_o) begin
      req_o  <= 1'b1;
      addr_o <= addr_i;
      npc_o  <= npc_i;
      sr_o   <= sr_i;
    end else if (req_o && ack_i) begin
      req_o <= 1'b0;
    end
  end

  a_r9_req_held: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> req_o);
  a_r9_frame_steady: assert property (@(posedge clk) disable iff (rst)
    (req_o && !ack_i) |=> ($stable(addr_o) && $stable(npc_o) && $stable(sr_o)));
  a_r2_fire_raises: assert property (@(posedge clk) disable iff (rst)
    (fire_i && !req_o) |=> req_o);
endmodule

// File: rtl/trace_exc_ctrl.sv
module trace_exc_ctrl
  import trace_pkg::*;
#(
  parameter int AW   = 32,
  parameter int SRW  = 16,
  parameter int THI  = 15,
  parameter int VOW  = 12,
  parameter int VEC  = TRACE_VEC
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [SRW-1:0] sr_i,
  input  logic           insn_start_i,
  input  logic [AW-1:0]  insn_addr_i,
  input  logic           pc_jump_i,
  input  logic           br_taken_i,
  input  logic           retire_i,
  input  logic [AW-1:0]  next_pc_i,
  input  logic           irq_take_i,
  input  logic           fault_i,
  input  logic           abort_i,
  input  logic           rte_resume_i,
  input  logic           trace_ack_i,
  output logic           trace_req_o,
  output logic [AW-1:0]  frm_insn_addr_o,
  output logic [VOW-1:0] frm_vec_off_o,
  output logic [AW-1:0]  frm_next_pc_o,
  output logic [SRW-1:0] frm_sr_o
);
  localparam logic [VOW-1:0] VOFF = VOW'(vec_offset(VEC));

  logic          fire;
  logic [AW-1:0] ctx_addr;

  trace_ctx #(.AW(AW), .SRW(SRW), .THI(THI)) u_ctx (
    .clk      (clk),
    .rst      (rst),
    .hold_i   (trace_req_o),
    .sr_i     (sr_i),
    .start_i  (insn_start_i),
    .addr_i   (insn_addr_i),
    .flow_i   (pc_jump_i | br_taken_i),
    .retire_i (retire_i),
    .irq_i    (irq_take_i),
    .fault_i  (fault_i),
    .abort_i  (abort_i),
    .rte_i    (rte_resume_i),
    .fire_o   (fire),
    .addr_o   (ctx_addr)
  );

  trace_frame #(.AW(AW), .SRW(SRW)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .fire_i (fire),
    .ack_i  (trace_ack_i),
    .addr_i (ctx_addr),
    .npc_i  (next_pc_i),
    .sr_i   (sr_i),
    .req_o  (trace_req_o),
    .addr_o (frm_insn_addr_o),
    .npc_o  (frm_next_pc_o),
    .sr_o   (frm_sr_o)
  );

  assign frm_vec_off_o = VOFF;

  a_r9_drop_on_ack: assert property (@(posedge clk) disable iff (rst)
    (trace_req_o && trace_ack_i) |=> !trace_req_o);
endmodule

// File: tb/trace_exc_ctrl_test.sv
module trace_exc_ctrl_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] p;
    logic [15:0] s;
  } exp_t;

  logic        clk = 0, rst = 1;
  logic [15:0] sr_i = 0;
  logic        insn_start_i = 0, pc_jump_i = 0, br_taken_i = 0, retire_i = 0;
  logic [31:0] insn_addr_i = 0, next_pc_i = 0;
  logic        irq_take_i = 0, fault_i = 0, abort_i = 0, rte_resume_i = 0, trace_ack_i = 0;
  logic        trace_req_o;
  logic [31:0] frm_insn_addr_o, frm_next_pc_o;
  logic [11:0] frm_vec_off_o;
  logic [15:0] frm_sr_o;

  int checks = 0, errors = 0;
  int ack_delay = 1;
  int wait_n = 0;
  exp_t  q[$];
  string qtag[$];
  exp_t  snap;
  bit    done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_exc_ctrl uut (
    .clk(clk), .rst(rst), .sr_i(sr_i), .insn_start_i(insn_start_i),
    .insn_addr_i(insn_addr_i), .pc_jump_i(pc_jump_i), .br_taken_i(br_taken_i),
    .retire_i(retire_i), .next_pc_i(next_pc_i), .irq_take_i(irq_take_i),
    .fault_i(fault_i), .abort_i(abort_i), .rte_resume_i(rte_resume_i),
    .trace_ack_i(trace_ack_i), .trace_req_o(trace_req_o),
    .frm_insn_addr_o(frm_insn_addr_o), .frm_vec_off_o(frm_vec_off_o),
    .frm_next_pc_o(frm_next_pc_o), .frm_sr_o(frm_sr_o)
  );

  function automatic logic [15:0] sr_of(input logic [1:0] m);
    return {m, 14'h0700};
  endfunction

  task automatic push(input exp_t e, input string tag);
    q.push_back(e);
    qtag.push_back(tag);
  endtask

  // monitor: compares each trace request against the scoreboard
  always @(negedge clk) begin
    if (rst) begin
      trace_ack_i = 0;
      wait_n = 0;
    end else if (trace_req_o) begin
      if (wait_n == 0) begin
        snap = '{a: frm_insn_addr_o, p: frm_next_pc_o, s: frm_sr_o};
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL unexpected trace: actual addr=%h expected no request", frm_insn_addr_o);
        end else begin
          if (snap != q[0] || frm_vec_off_o != 12'h024) begin
            errors++;
            $display("FAIL %s/R11: actual addr=%h pc=%h sr=%h vec=%h expected addr=%h pc=%h sr=%h vec=024",
                     qtag[0], snap.a, snap.p, snap.s, frm_vec_off_o, q[0].a, q[0].p, q[0].s);
          end
          void'(q.pop_front());
          void'(qtag.pop_front());
        end
      end else if (wait_n == ack_delay) begin
        checks++;  // R9: frame unchanged while request waits
        if (snap != '{a: frm_insn_addr_o, p: frm_next_pc_o, s: frm_sr_o}) begin
          errors++;
          $display("FAIL R9: actual addr=%h pc=%h sr=%h expected addr=%h pc=%h sr=%h",
                   frm_insn_addr_o, frm_next_pc_o, frm_sr_o, snap.a, snap.p, snap.s);
        end
      end
      if (wait_n >= ack_delay) trace_ack_i = 1;
      wait_n++;
    end else begin
      trace_ack_i = 0;
      wait_n = 0;
    end
  end

  // kind: 0 retire, 1 interrupt, 2 fault, 3 abort
  task automatic insn(input logic [1:0] m, input logic [1:0] m_late, input logic [31:0] a,
                      input logic [31:0] npc, input bit flow, input bit via_branch,
                      input int kind, input bit rte, input bit expect_tr, input string tag);
    @(negedge clk);
    sr_i = sr_of(m); insn_start_i = 1; insn_addr_i = a;
    @(negedge clk);
    insn_start_i = 0; sr_i = sr_of(m_late);
    if (via_branch) br_taken_i = flow; else pc_jump_i = flow;
    @(negedge clk);
    pc_jump_i = 0; br_taken_i = 0;
    case (kind)
      0: begin retire_i = 1; next_pc_i = npc; rte_resume_i = rte; end
      1: irq_take_i = 1;
      2: fault_i = 1;
      default: abort_i = 1;
    endcase
    if (expect_tr) push('{a: a, p: npc, s: sr_of(m_late)}, tag);
    @(negedge clk);
    retire_i = 0; rte_resume_i = 0; irq_take_i = 0; fault_i = 0; abort_i = 0;
  endtask

  task automatic lone_retire(input logic [31:0] npc, input logic [15:0] s);
    @(negedge clk);
    sr_i = s; retire_i = 1; next_pc_i = npc;
    @(negedge clk);
    retire_i = 0;
  endtask

  task automatic settle_idle(input string tag);
    repeat (ack_delay + 5) @(negedge clk);
    checks++;
    if (q.size() != 0 || trace_req_o) begin
      errors++;
      $display("FAIL %s: actual pending=%0d req=%b expected pending=0 req=0", tag, q.size(), trace_req_o);
      q.delete(); qtag.delete();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual run still active expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    checks++;  // R1 reset state
    if (trace_req_o !== 1'b0 || frm_vec_off_o !== 12'h024) begin
      errors++;
      $display("FAIL R1/R11: actual req=%b vec=%h expected req=0 vec=024", trace_req_o, frm_vec_off_o);
    end
    lone_retire(32'h100, sr_of(2'b10));
    settle_idle("R1 retire without start");

    insn(2'b10, 2'b10, 32'h1000, 32'h1004, 0, 0, 0, 0, 1, "R2 every-insn");
    settle_idle("R2 drain");
    insn(2'b10, 2'b00, 32'h2000, 32'h2002, 0, 0, 0, 0, 1, "R3 late clear");
    settle_idle("R3 drain");
    insn(2'b00, 2'b10, 32'h2100, 32'h2104, 1, 0, 0, 0, 0, "R3 late set");
    settle_idle("R3 late set ignored");

    insn(2'b01, 2'b01, 32'h3000, 32'h3800, 1, 0, 0, 0, 1, "R4 jump");
    settle_idle("R4 drain");
    insn(2'b01, 2'b01, 32'h3100, 32'h3200, 1, 1, 0, 0, 1, "R4 branch taken");
    settle_idle("R4 drain");
    insn(2'b01, 2'b01, 32'h3300, 32'h3302, 0, 0, 0, 0, 0, "R4");
    settle_idle("R4 untaken no trace");

    insn(2'b00, 2'b00, 32'h4000, 32'h4800, 1, 0, 0, 0, 0, "R5");
    settle_idle("R5 mode 00");
    insn(2'b11, 2'b11, 32'h4100, 32'h4900, 1, 0, 0, 0, 0, "R5");
    settle_idle("R5 mode 11");

    insn(2'b10, 2'b10, 32'h5000, 32'h0, 0, 0, 1, 0, 0, "R6");
    lone_retire(32'h5004, sr_of(2'b10));
    settle_idle("R6 interrupt cancels");
    insn(2'b10, 2'b10, 32'h5100, 32'h0, 0, 0, 2, 0, 0, "R6");
    lone_retire(32'h5104, sr_of(2'b10));
    settle_idle("R6 fault cancels");

    insn(2'b10, 2'b10, 32'h6000, 32'h0, 0, 0, 3, 0, 0, "R7");
    settle_idle("R7 abort defers");
    insn(2'b00, 2'b00, 32'h7000, 32'h7002, 0, 0, 0, 0, 0, "R7 handler");
    insn(2'b10, 2'b10, 32'h7010, 32'h6000, 0, 0, 0, 1, 0, "R8");
    settle_idle("R8 resume return not traced");
    push('{a: 32'h6000, p: 32'h6006, s: sr_of(2'b00)}, "R7 resumed");
    lone_retire(32'h6006, sr_of(2'b00));
    settle_idle("R7 drain");

    insn(2'b10, 2'b10, 32'h7100, 32'h7102, 0, 0, 0, 1, 0, "R8");
    settle_idle("R8 plain resume return");

    @(negedge clk);
    sr_i = sr_of(2'b10); insn_start_i = 1; retire_i = 1;
    insn_addr_i = 32'h8000; next_pc_i = 32'h8002;
    push('{a: 32'h8000, p: 32'h8002, s: sr_of(2'b10)}, "R12 one-cycle");
    @(negedge clk);
    insn_start_i = 0; retire_i = 0;
    settle_idle("R12 drain");

    ack_delay = 9;
    insn(2'b10, 2'b10, 32'h9000, 32'h9004, 0, 0, 0, 0, 1, "R9 held");
    insn(2'b10, 2'b10, 32'h9100, 32'h9104, 1, 0, 0, 0, 0, "R10");
    settle_idle("R10 events during request ignored");
    ack_delay = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule